// File: doc/BRIEF.md
# Ethernet Receive Frame Qualifier

This block sits on the receive path of an Ethernet MAC, directly behind the deserialiser. It watches a byte stream whose beats carry start-of-frame and end-of-frame markers. For every frame it runs a CRC-32 check and counts the bytes, with the trailing frame check sequence included in the count. When the last byte has been taken it issues a one-cycle status word. The word holds a short-frame flag, a checksum-failure flag and the saturated byte count, along with a keep/discard verdict for the receive buffer that follows.

Software configuration arrives on three static bits. One lets frames that fail the checksum still be kept. The other two enable an interrupt pulse for each kind of event. Address filtering, buffer storage and line decoding belong to other blocks.

Top module: `rx_frame_checker`

## Requirements
- R1: After reset is released and before any end-of-frame beat, `stat_valid` and `irq` are 0.
- R2: A beat counts only when `in_valid` is 1. The status outputs are valid, with `stat_valid` = 1, in exactly the one cycle after the clock edge that accepts a beat with `in_eof` = 1. `stat_valid` is 0 in the cycle after that unless another end beat was accepted.
- R3: `stat_runt` is 1 when the frame length, counting the 4 checksum bytes, is below `MIN_LEN` (default 64). The length runs from the `in_sof` beat up to and including the `in_eof` beat.
- R4: A frame of exactly `MIN_LEN` bytes, or longer, has `stat_runt` = 0.
- R5: `stat_crc_err` is 0 only when the frame's last four bytes are the correct CRC-32 of the bytes before them. The CRC uses the 802.3 polynomial, reflected (bit 0 of each byte first), with a preset of all ones and the result inverted. The checksum is appended least significant byte first. This is equivalent to the register residue 0xC704DD7B in MSB-first notation.
- R6: `stat_keep` is 1 for a frame whose checksum is correct. For a frame with `stat_crc_err` = 1, `stat_keep` equals `cfg_accept_bad_crc` as sampled on the end beat.
- R7: When `cfg_irq_en_crc` is 1 on the end beat, a checksum failure drives `irq` to 1 in the status cycle. When the bit is 0, a checksum failure alone leaves `irq` at 0.
- R8: When `cfg_irq_en_runt` is 1 on the end beat, a short frame drives `irq` to 1 in the status cycle. When the bit is 0, a short frame alone leaves `irq` at 0. `irq` is 0 whenever `stat_valid` is 0.
- R9: `stat_len` reports the frame length, saturating at 2^`LEN_W`-1. A longer frame reports that maximum and is never flagged as short.
- R10: Idle cycles inside a frame, with `in_valid` = 0, have no effect on the result whatever `in_sof`, `in_eof` and `in_data` hold.
- R11: A beat with `in_sof` = 1 restarts the checksum and the length. Any unfinished earlier frame is abandoned and produces no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte beat present |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| in_data | input | 8 | Received byte |
| cfg_accept_bad_crc | input | 1 | Keep frames that fail the checksum |
| cfg_irq_en_crc | input | 1 | Interrupt enable for checksum failure |
| cfg_irq_en_runt | input | 1 | Interrupt enable for short frames |
| stat_valid | output | 1 | Status word valid this cycle |
| stat_runt | output | 1 | Frame shorter than MIN_LEN |
| stat_crc_err | output | 1 | Checksum failure |
| stat_keep | output | 1 | Buffer should keep the frame |
| stat_len | output | LEN_W | Saturated frame length in bytes |
| irq | output | 1 | Enabled event pulse |

## Verification
The bench builds the block with `LEN_W` = 8 and the default `MIN_LEN` of 64. The counter therefore saturates at 255, so frames of 300 bytes take it into saturation while runs stay short. Frame lengths are drawn at random on both sides of the 64-byte boundary, and the exact values 63 and 64 are also driven directly. Idle gaps carrying junk markers, a restart in mid-frame and back-to-back single-cycle status windows cover the timing rules.

// File: rtl/rx_chk_pkg.sv
// Package: shared constants and the byte-wise CRC-32 step for the receive
// frame qualifier. Assumes reflected (LSB-first) bit order on the line.
package rx_chk_pkg;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [31:0] CRC_PRESET    = 32'hFFFF_FFFF;
    // Register residue after a good frame, reflected form of 0xC704DD7B.
    localparam logic [31:0] CRC_GOOD_RES  = 32'hDEBB_20E3;

    // Advances the reflected CRC register by one byte.
    function automatic logic [31:0] crc_step(input logic [31:0] c_in,
                                             input logic [7:0]  d);
        logic [31:0] c;
        logic        fb;
        c = c_in;
        for (int b = 0; b < 8; b++) begin
            fb = c[0] ^ d[b];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY_REFL;
        end
        return c;
    endfunction
endpackage

// File: rtl/rx_crc32.sv
// rx_crc32: running CRC-32 over accepted beats. A start beat reloads the
// preset before folding in its byte. crc_next shows the value including the
// current beat so the end beat can be judged in the same cycle.
module rx_crc32
    import rx_chk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        beat_en,
    input  logic        beat_sof,
    input  logic [7:0]  beat_data,
    output logic [31:0] crc_next
);
    logic [31:0] crc_q;

    // Next register value for the current beat.
    always_comb crc_next = crc_step(beat_sof ? CRC_PRESET : crc_q, beat_data);

    // Hold the running CRC, advancing only on accepted beats.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc_q <= CRC_PRESET;
        else if (beat_en) crc_q <= crc_next;
    end
endmodule

// File: rtl/rx_len_counter.sv
// rx_len_counter: saturating byte counter. A start beat sets it to one. It
// stops at 2^LEN_W-1 so an oversized frame cannot wrap into a short one.
module rx_len_counter #(
    parameter int unsigned LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_en,
    input  logic             beat_sof,
    output logic [LEN_W-1:0] len_next
);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;
    logic [LEN_W-1:0] len_q;

    // Length including the current beat.
    always_comb begin
        if (beat_sof)              len_next = LEN_W'(1);
        else if (len_q == LEN_MAX) len_next = LEN_MAX;
        else                       len_next = len_q + LEN_W'(1);
    end

    // Hold the count, advancing only on accepted beats.
    always_ff @(posedge clk) begin
        if (!rst_n)       len_q <= '0;
        else if (beat_en) len_q <= len_next;
    end

    // R9
    len_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q == LEN_MAX && !(beat_en && beat_sof)) |=> (len_q == LEN_MAX));
endmodule

// File: rtl/rx_status_gen.sv
// rx_status_gen: captures the verdict on the end beat and presents it for one
// cycle. Assumes crc_next and len_next already include the end beat's byte.
module rx_status_gen
    import rx_chk_pkg::*;
#(
    parameter int unsigned LEN_W   = 12,
    parameter int unsigned MIN_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             end_beat,
    input  logic [31:0]      crc_next,
    input  logic [LEN_W-1:0] len_next,
    input  logic             cfg_accept_bad_crc,
    input  logic             cfg_irq_en_crc,
    input  logic             cfg_irq_en_runt,
    output logic             stat_valid,
    output logic             stat_runt,
    output logic             stat_crc_err,
    output logic             stat_keep,
    output logic [LEN_W-1:0] stat_len,
    output logic             irq
);
    logic runt_c, crc_bad_c;

    // Judge the frame as it closes.
    always_comb begin
        runt_c    = 32'(len_next) < MIN_LEN;
        crc_bad_c = crc_next != CRC_GOOD_RES;
    end

    // Register the verdict; the valid strobe lasts a single cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_valid   <= 1'b0;
            stat_runt    <= 1'b0;
            stat_crc_err <= 1'b0;
            stat_keep    <= 1'b0;
            stat_len     <= '0;
            irq          <= 1'b0;
        end else begin
            stat_valid <= end_beat;
            irq        <= end_beat && ((crc_bad_c && cfg_irq_en_crc) ||
                                       (runt_c && cfg_irq_en_runt));
            if (end_beat) begin
                stat_runt    <= runt_c;
                stat_crc_err <= crc_bad_c;
                stat_keep    <= !crc_bad_c || cfg_accept_bad_crc;
                stat_len     <= len_next;
            end
        end
    end

    // R2
    valid_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> $past(end_beat));
    // R6
    keep_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !stat_crc_err) |-> stat_keep);
    // R8
    irq_with_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat_valid);
    // R4
    long_not_runt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && 32'(stat_len) >= MIN_LEN) |-> !stat_runt);
endmodule

// File: rtl/rx_frame_checker.sv
// rx_frame_checker: receive frame qualifier. Takes a byte stream with frame
// markers and emits short-frame and checksum flags, length, a keep verdict and
// an enabled interrupt pulse, all valid in the cycle after the end beat.
module rx_frame_checker #(
    parameter int unsigned LEN_W   = 12,
    parameter int unsigned MIN_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    input  logic             cfg_accept_bad_crc,
    input  logic             cfg_irq_en_crc,
    input  logic             cfg_irq_en_runt,
    output logic             stat_valid,
    output logic             stat_runt,
    output logic             stat_crc_err,
    output logic             stat_keep,
    output logic [LEN_W-1:0] stat_len,
    output logic             irq
);
    logic             beat_en, end_beat;
    logic [31:0]      crc_next;
    logic [LEN_W-1:0] len_next;

    // Qualify markers with the valid strobe.
    always_comb begin
        beat_en  = in_valid;
        end_beat = in_valid && in_eof;
    end

    rx_crc32 u_crc (
        .clk(clk), .rst_n(rst_n), .beat_en(beat_en), .beat_sof(in_sof),
        .beat_data(in_data), .crc_next(crc_next)
    );

    rx_len_counter #(.LEN_W(LEN_W)) u_len (
        .clk(clk), .rst_n(rst_n), .beat_en(beat_en), .beat_sof(in_sof),
        .len_next(len_next)
    );

    rx_status_gen #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_stat (
        .clk(clk), .rst_n(rst_n), .end_beat(end_beat), .crc_next(crc_next),
        .len_next(len_next), .cfg_accept_bad_crc(cfg_accept_bad_crc),
        .cfg_irq_en_crc(cfg_irq_en_crc), .cfg_irq_en_runt(cfg_irq_en_runt),
        .stat_valid(stat_valid), .stat_runt(stat_runt),
        .stat_crc_err(stat_crc_err), .stat_keep(stat_keep),
        .stat_len(stat_len), .irq(irq)
    );

    // R1
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_valid |-> !irq);
endmodule

// File: tb/rx_frame_checker_bench.sv
module rx_frame_checker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 8;
    localparam int MIN_LEN    = 64;
    localparam int LEN_MAX    = (1 << LEN_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic cfg_acc = 1'b0, cfg_iec = 1'b0, cfg_ier = 1'b0;
    logic stat_valid, stat_runt, stat_crc_err, stat_keep, irq;
    logic [LEN_W-1:0] stat_len;

    int tests = 0;
    int fails = 0;
    logic [7:0] fr [0:511];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_frame_checker #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_rx_frame_checker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_data(in_data), .cfg_accept_bad_crc(cfg_acc),
        .cfg_irq_en_crc(cfg_iec), .cfg_irq_en_runt(cfg_ier),
        .stat_valid(stat_valid), .stat_runt(stat_runt),
        .stat_crc_err(stat_crc_err), .stat_keep(stat_keep),
        .stat_len(stat_len), .irq(irq)
    );

    task automatic check(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Standard 802.3 frame check sequence over fr[0..n-1].
    function automatic logic [31:0] fcs_of(int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++)
                c = (c[0] ^ fr[i][b]) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        return ~c;
    endfunction

    // Fill a payload of p bytes and append its checksum; optionally corrupt it.
    task automatic build(int p, bit corrupt);
        logic [31:0] f;
        for (int i = 0; i < p; i++) fr[i] = 8'($urandom);
        f = fcs_of(p);
        for (int k = 0; k < 4; k++) fr[p+k] = f[8*k +: 8];
        if (corrupt) fr[$urandom_range(p+3, 0)] ^= 8'(1 << $urandom_range(7, 0));
    endtask

    // Drive n bytes of fr; gaps insert idle cycles with junk markers.
    task automatic drive(int n, bit gaps, bit close);
        for (int i = 0; i < n; i++) begin
            if (gaps && $urandom_range(3, 0) == 0) begin
                in_valid = 1'b0; in_sof = 1'($urandom); in_eof = 1'($urandom);
                in_data = 8'($urandom);
                @(negedge clk);
            end
            in_valid = 1'b1; in_sof = (i == 0); in_eof = close && (i == n-1);
            in_data = fr[i];
            @(negedge clk);
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    // After the end beat's edge, compare the status window with the model.
    task automatic expect_status(int total, bit bad);
        bit runt = total < MIN_LEN;
        int len  = (total > LEN_MAX) ? LEN_MAX : total;
        check("R2", "stat_valid", stat_valid, 1);
        check(runt ? "R3" : "R4", "stat_runt", stat_runt, runt);
        check("R5", "stat_crc_err", stat_crc_err, bad);
        check("R6", "stat_keep", stat_keep, (!bad) || cfg_acc);
        check(runt ? "R8" : "R7", "irq", irq, (bad && cfg_iec) || (runt && cfg_ier));
        check("R9", "stat_len", stat_len, len);
        @(negedge clk);
        check("R2", "stat_valid after window", stat_valid, 0);
        check("R8", "irq after window", irq, 0);
    endtask

    task automatic frame(int p, bit bad, bit gaps);
        build(p, bad);
        drive(p + 4, gaps, 1'b1);
        expect_status(p + 4, bad);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "stat_valid after reset", stat_valid, 0);
        check("R1", "irq after reset", irq, 0);

        // Directed boundaries around the minimum size
        cfg_acc = 0; cfg_iec = 1; cfg_ier = 1;
        frame(59, 0, 0);   // 63 total: runt
        frame(60, 0, 0);   // 64 total: legal
        frame(60, 1, 0);   // bad CRC, discarded, irq
        cfg_acc = 1; cfg_iec = 0;
        frame(60, 1, 0);   // bad CRC kept, no irq (R7)
        cfg_ier = 0;
        frame(20, 0, 0);   // runt without enable: irq low (R8)
        // Saturation with a 300-byte frame (R9)
        cfg_ier = 1;
        frame(296, 0, 0);
        // R10: gaps with junk markers
        frame(70, 0, 1);
        frame(30, 1, 1);
        // R11: abandoned partial frame then a fresh one
        build(40, 0);
        drive(12, 0, 1'b0);
        @(negedge clk);
        check("R11", "no status for abandoned frame", stat_valid, 0);
        frame(62, 0, 0);
        // Back-to-back single-byte frames: both windows present (R2)
        fr[0] = 8'h55;
        in_valid = 1; in_sof = 1; in_eof = 1; in_data = 8'h55;
        @(negedge clk);
        check("R2", "first single-byte status", stat_valid, 1);
        check("R3", "single-byte runt", stat_runt, 1);
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0;
        check("R2", "second single-byte status", stat_valid, 1);
        @(negedge clk);
        check("R2", "window closed", stat_valid, 0);

        // Constrained random frames
        for (int n = 0; n < 40; n++) begin
            cfg_acc = 1'($urandom); cfg_iec = 1'($urandom); cfg_ier = 1'($urandom);
            frame($urandom_range(100, 1), 1'($urandom_range(2, 0) == 0),
                  1'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule